// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous SRAM with pipelined reads. Each word has four byte lanes of nine bits. The bus is shared for reads and writes. Address, control and write data are taken on the rising clock edge. Read data passes through the array read register and then through an output register. A new burst starts on one of two address strobes.

- The processor strobe always starts a read.
- The controller strobe starts a read or a write, depending on the write enables in the same cycle.

After a strobe, a 2-bit counter supplies the low two address bits. The counter walks the four words of the aligned group in linear or interleaved order, and the advance input steps it.

The shared bus is split into `dq_in`, `dq_out` and `dq_oe`, to be joined at a pad tristate. The output enable and the sleep input gate `dq_oe` combinationally. A deselect clears the output pipeline over two clock edges, so the last read word stays on the bus for one more cycle. While sleep is high, no access takes place and the array keeps its contents.

Top module: `burst_sram`

## Requirements
- R1: Synchronous reset clears the output pipeline and the burst state. After reset, `dq_oe` is 0, and cycles with no strobe make no access until a strobe arrives.
- R2: A read access sampled at edge E shows its word on `dq_out` with `dq_oe`=1 after edge E+1, provided `out_en`=1 and `sleep`=0.
- R3: The address and the three chip enables are taken only on an edge where `proc_stb` or `ctrl_stb` is 1. Changes to them on other cycles do not disturb a running burst.
- R4: A strobe selects the device only when `ce_pipe`, `ce_exp_a` and `ce_exp_b` are all 1. A strobe with any of them at 0 deselects the device, and later cycles without a strobe make no access.
- R5: With `order_ilv`=0, the low two address bits of a burst are (start + count) mod 4, so a start of 1 gives 1,2,3,0.
- R6: With `order_ilv`=1, the low two address bits are start XOR count, so a start of 1 gives 1,0,3,2.
- R7: After the strobe cycle, every non-strobe cycle of a selected burst is an access. With `adv`=1 the count steps by one before the access. With `adv`=0 the same address is accessed again.
- R8: A cycle with `proc_stb`=1 is always a read, whatever the write enables. `proc_stb` takes priority when both strobes are high.
- R9: A controller-strobe start, or a burst continuation cycle, with a non-zero write mask writes `dq_in` at that access address. A write cycle never drives the bus.
- R10: Lane i is bits [9i+8:9i]. It is written when `byte_we[i]`=1 and `byte_we_en`=1. `global_we`=1 writes all four lanes regardless of the other two inputs. A zero mask makes the cycle a read.
- R11: `out_en`=0 forces `dq_oe` to 0 at once, with no clock edge needed.
- R12: After a deselecting strobe at edge D, the previous read word stays driven until edge D+1. The bus is released after edge D+1.
- R13: While `sleep`=1, `dq_oe` is 0 at once. Strobes, advances and writes on those edges are ignored, and the array contents and the burst position are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, taken on a strobe |
| proc_stb | input | 1 | Processor strobe: starts a read burst |
| ctrl_stb | input | 1 | Controller strobe: starts a read or write burst |
| adv | input | 1 | Steps the burst counter |
| ce_pipe | input | 1 | Chip enable, active high |
| ce_exp_a | input | 1 | Depth-expansion enable, active high |
| ce_exp_b | input | 1 | Depth-expansion enable, active high |
| byte_we | input | LANES | Per-lane write enables |
| byte_we_en | input | 1 | Qualifies `byte_we` |
| global_we | input | 1 | Writes all lanes |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Sleep: blocks accesses and releases the bus |
| dq_in | input | LANES*LANE_W | Write data from the shared bus |
| dq_out | output | LANES*LANE_W | Read data toward the shared bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench builds the block with ADDR_W=6, so the array holds 64 words, with the default four lanes of nine bits. With so few words, random traffic keeps returning to the same entries. This means partial-lane merges, ignored writes during sleep and processor-strobe cycles, and reads of old data are all caught by the bench's shadow array. Sixteen aligned groups let bursts start at every offset in both orders, and random deselects and sleeps land in the middle of bursts and in the middle of the two-stage output pipeline.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;

  // low address bits for beat 'step' of a burst that began at 'start'
  function automatic logic [1:0] burst_slot(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input logic       ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              proc_stb,
  input  logic              ctrl_stb,
  input  logic              adv,
  input  logic              sel,
  input  logic              sleep,
  input  logic              order_ilv,
  input  logic              wr_req,
  output logic [ADDR_W-1:0] acc_addr,
  output acc_kind_t         acc_kind
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_nx;
  logic              active_q;
  logic              start;
  logic              cont;

  always_comb begin
    start    = !sleep && (proc_stb || ctrl_stb);
    cont     = !sleep && !start && active_q;
    cnt_nx   = adv ? cnt_q + 2'd1 : cnt_q;
    acc_addr = {base_q[ADDR_W-1:2], burst_slot(base_q[1:0], cnt_nx, order_ilv)};
    acc_kind = ACC_IDLE;
    if (start && sel) begin
      acc_addr = addr;
      acc_kind = (!proc_stb && wr_req) ? ACC_WRITE : ACC_READ;
    end else if (cont) begin
      acc_kind = wr_req ? ACC_WRITE : ACC_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start) begin
      active_q <= sel;
      if (sel) begin
        base_q <= addr;
        cnt_q  <= '0;
      end
    end else if (cont) begin
      cnt_q <= cnt_nx;
    end
  end

  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    sleep |=> $stable(base_q) && $stable(cnt_q) && $stable(active_q)); // R13

  AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (rst)
    (start && !sel) |=> (proc_stb || ctrl_stb || acc_kind == ACC_IDLE)); // R4

endmodule

// File: rtl/byte_lane_array.sv
module byte_lane_array #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES-1:0]          lane_we,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      rdata[g*LANE_W +: LANE_W] <= mem[addr];
    end
  end

endmodule

// File: rtl/read_out_pipe.sv
module read_out_pipe #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              out_en,
  input  logic              sleep,
  output logic [DATA_W-1:0] dout,
  output logic              doe,
  output logic              valid
);

  logic              vld0_q;
  logic              vld1_q;
  logic [DATA_W-1:0] dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld0_q <= 1'b0;
      vld1_q <= 1'b0;
    end else begin
      vld0_q <= rd_fire;
      vld1_q <= vld0_q;
    end
  end

  always_ff @(posedge clk) begin
    if (vld0_q) dout_q <= arr_data;
  end

  assign dout  = dout_q;
  assign valid = vld1_q;
  assign doe   = out_en && !sleep && vld1_q;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !vld0_q && !vld1_q); // R1

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    proc_stb,
  input  logic                    ctrl_stb,
  input  logic                    adv,
  input  logic                    ce_pipe,
  input  logic                    ce_exp_a,
  input  logic                    ce_exp_b,
  input  logic [LANES-1:0]        byte_we,
  input  logic                    byte_we_en,
  input  logic                    global_we,
  input  logic                    order_ilv,
  input  logic                    out_en,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int DATA_W = LANES * LANE_W;

  logic              sel;
  logic [LANES-1:0]  wmask;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] acc_addr;
  acc_kind_t         acc_kind;
  logic [DATA_W-1:0] arr_q;
  logic              pipe_valid;

  assign sel     = ce_pipe && ce_exp_a && ce_exp_b;
  assign wmask   = global_we ? {LANES{1'b1}} : (byte_we_en ? byte_we : '0);
  assign lane_we = (acc_kind == ACC_WRITE) ? wmask : '0;

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .proc_stb  (proc_stb),
    .ctrl_stb  (ctrl_stb),
    .adv       (adv),
    .sel       (sel),
    .sleep     (sleep),
    .order_ilv (order_ilv),
    .wr_req    (|wmask),
    .acc_addr  (acc_addr),
    .acc_kind  (acc_kind)
  );

  byte_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk     (clk),
    .addr    (acc_addr),
    .lane_we (lane_we),
    .wdata   (dq_in),
    .rdata   (arr_q)
  );

  read_out_pipe #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .rd_fire  (acc_kind == ACC_READ),
    .arr_data (arr_q),
    .out_en   (out_en),
    .sleep    (sleep),
    .dout     (dq_out),
    .doe      (dq_oe),
    .valid    (pipe_valid)
  );

  AST_READ_TWO_EDGE: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == ACC_READ) |=> ##1 pipe_valid); // R2

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == ACC_WRITE) |=> ##1 !pipe_valid); // R9

  AST_PROC_IS_READ: assert property (@(posedge clk) disable iff (rst)
    (!sleep && proc_stb && sel) |-> acc_kind == ACC_READ); // R8

  AST_DESEL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!sleep && (proc_stb || ctrl_stb) && !sel) |=> ##1 !pipe_valid); // R12

endmodule

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
module sim_burst_sram;

  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          ps = 0, cs = 0, adv = 0;
  logic          ce0 = 1, ce1 = 1, ce2 = 1;
  logic [3:0]    bwe = '0;
  logic          bwen = 0, gw = 0, ilv = 0, oe = 1, slp = 0;
  logic [35:0]   din = '0;
  logic [35:0]   dout;
  logic          doe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench shadow model
  logic [35:0]   mmem [NW];
  logic          m_act = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          m_v0 = 0, m_v1 = 0;
  logic [35:0]   m_d0 = '0, m_d1 = '0;

  always #4 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANE_W(9), .LANES(4)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .proc_stb(ps), .ctrl_stb(cs), .adv(adv),
    .ce_pipe(ce0), .ce_exp_a(ce1), .ce_exp_b(ce2), .byte_we(bwe),
    .byte_we_en(bwen), .global_we(gw), .order_ilv(ilv), .out_en(oe),
    .sleep(slp), .dq_in(din), .dq_out(dout), .dq_oe(doe)
  );

  function automatic logic [1:0] slot(input logic [1:0] s, input logic [1:0] c, input logic il);
    if (il) return s ^ c;
    return s + c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    logic [3:0]    mask;
    logic [AW-1:0] a;
    bit            acc;
    bit            wr;
    logic [35:0]   rd;
    mask = gw ? 4'hF : (bwen ? bwe : 4'h0);
    acc = 0; wr = 0; a = '0; rd = '0;
    if (rst) begin
      m_act = 0; m_cnt = '0; m_base = '0;
      m_v0 = 0; m_v1 = 0;
      return;
    end
    if (slp) begin
      acc = 0;
    end else if (ps || cs) begin
      if (ce0 && ce1 && ce2) begin
        m_act = 1; m_base = addr; m_cnt = '0;
        a = addr; acc = 1; wr = !ps && (mask != 0);
      end else begin
        m_act = 0;
      end
    end else if (m_act) begin
      if (adv) m_cnt = m_cnt + 2'd1;
      a = {m_base[AW-1:2], slot(m_base[1:0], m_cnt, ilv)};
      acc = 1; wr = (mask != 0);
    end
    if (acc && wr) begin
      for (int l = 0; l < 4; l++)
        if (mask[l]) mmem[a][l*9 +: 9] = din[l*9 +: 9];
    end
    if (acc && !wr) rd = mmem[a];
    if (m_v0) m_d1 = m_d0;
    m_v1 = m_v0;
    m_v0 = acc && !wr;
    if (m_v0) m_d0 = rd;
  endtask

  task automatic step(input string tag);
    logic exp_oe;
    model_update();
    @(posedge clk);
    @(negedge clk);
    exp_oe = oe && !slp && m_v1;
    chk(doe == exp_oe, tag, {35'd0, doe}, {35'd0, exp_oe});
    if (exp_oe && doe) chk(dout == m_d1, tag, dout, m_d1);
  endtask

  task automatic idle();
    ps = 0; cs = 0; adv = 0; bwe = '0; bwen = 0; gw = 0;
  endtask

  task automatic read_burst(input logic [AW-1:0] a, input logic il, input string tag);
    ilv = il; idle(); ps = 1; addr = a;
    step(tag);
    ps = 0; adv = 1;
    for (int k = 0; k < 3; k++) step(tag);
    adv = 0;
    step(tag);
    step(tag);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    @(negedge clk);
    rst = 1; idle();
    step("R1"); step("R1");
    rst = 0;
    step("R1");
    step("R1");

    // fill the array with known data using controller strobe writes
    for (int a = 0; a < NW; a++) begin
      idle(); cs = 1; gw = 1; addr = a[AW-1:0];
      din = {$urandom, $urandom};
      step("R9");
    end
    idle(); ps = 1; ce1 = 0; step("R4"); ce1 = 1; idle();
    step("R1");

    // burst orders, all four start offsets
    for (int s = 0; s < 4; s++) read_burst(AW'(8 + s), 1'b0, "R5");
    for (int s = 0; s < 4; s++) read_burst(AW'(12 + s), 1'b1, "R6");

    // advance / suspend pattern
    idle(); ps = 1; addr = 6'd21; step("R7");
    ps = 0; adv = 1; step("R7");
    adv = 0; step("R7");
    adv = 1; step("R7");
    idle(); step("R7");

    // processor strobe with write enables (and both strobes) is a read
    idle(); ps = 1; cs = 1; gw = 1; addr = 6'd33; din = 36'hF0F0F0F0F;
    step("R8");
    ps = 1; cs = 0; gw = 0; bwen = 1; bwe = 4'hF; step("R8");
    idle(); read_burst(6'd33, 1'b0, "R8");

    // byte lanes, global write, zero mask
    idle(); cs = 1; bwen = 1; bwe = 4'b0101; addr = 6'd40; din = 36'h123456789;
    step("R10");
    idle(); cs = 1; bwen = 0; bwe = 4'b1010; addr = 6'd41; din = 36'hABCDEF012;
    step("R10");
    idle(); cs = 1; gw = 1; bwen = 0; bwe = 4'h0; addr = 6'd42; din = 36'h0DEADBEEF;
    step("R10");
    idle(); read_burst(6'd40, 1'b0, "R10");

    // write in a continuation cycle
    idle(); cs = 1; addr = 6'd44; step("R9");
    cs = 0; adv = 1; bwen = 1; bwe = 4'b1000; din = 36'h876543210; step("R9");
    idle(); step("R9");
    read_burst(6'd44, 1'b0, "R9");

    // strobe-only capture of address and enables
    idle(); ps = 1; addr = 6'd16; step("R3");
    ps = 0; adv = 1; addr = 6'd45; ce0 = 0; ce2 = 0;
    for (int k = 0; k < 3; k++) step("R3");
    ce0 = 1; ce2 = 1; idle(); step("R3"); step("R3");

    // deselect without wait
    idle(); ps = 1; addr = 6'd30; step("R12");
    ps = 1; ce2 = 0; addr = 6'd31; step("R12");
    chk(doe == 1'b1, "R12", {35'd0, doe}, 36'd1);
    ps = 0; ce2 = 1; step("R12");
    chk(doe == 1'b0, "R12", {35'd0, doe}, 36'd0);
    step("R4"); step("R4");

    // asynchronous output enable
    idle(); ps = 1; addr = 6'd50; step("R11");
    idle(); step("R11");
    oe = 0; #1;
    chk(doe == 1'b0, "R11", {35'd0, doe}, 36'd0);
    oe = 1; #1;
    chk(doe == 1'b1, "R11", {35'd0, doe}, 36'd1);

    // sleep
    slp = 1; #1;
    chk(doe == 1'b0, "R13", {35'd0, doe}, 36'd0);
    idle(); cs = 1; gw = 1; addr = 6'd3; din = ~mmem[3];
    step("R13");
    idle(); ps = 1; addr = 6'd7; step("R13");
    idle(); slp = 0; step("R13");
    read_burst(6'd3, 1'b0, "R13");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      ps   = ($urandom % 8) == 0;
      cs   = !ps && (($urandom % 6) == 0);
      adv  = $urandom % 2;
      addr = $urandom;
      ce0  = ($urandom % 10) != 0;
      ce1  = ($urandom % 10) != 0;
      ce2  = ($urandom % 10) != 0;
      gw   = ($urandom % 5) == 0;
      bwen = $urandom % 2;
      bwe  = $urandom;
      oe   = ($urandom % 8) != 0;
      slp  = ($urandom % 20) == 0;
      ilv  = $urandom % 2;
      din  = {$urandom, $urandom};
      step("R2");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule